// File: doc/BRIEF.md
# Interrupt Pin Service Engine

This block keeps the per-pin request state of a 24-input interrupt router and decides when a pin turns into a delivery message. Line events arrive one per cycle as a pin number with a level. Each pin's routing entry is an input: mask, trigger mode, vector and destination. A pulse tells the block that software has just rewritten one entry. The processor side sends end-of-interrupt broadcasts that carry a vector, and answers each delivery with an accept bit in the same cycle.

Edge pins are delivered once per rising request. A repeated assertion while the request is still held is folded into the earlier one. Level pins carry a remote-acknowledge flag that blocks further delivery until a matching end-of-interrupt clears it. A pin that is still requesting when it is acknowledged is delivered again at once. Each pin counts these back-to-back re-deliveries. When the count reaches a threshold, the re-delivery is held back and handed to a delayed sweep, which throttles an interrupt storm. Pending deliveries leave one per cycle, lowest pin number first. A snapshot output gives the request register with already-delivered edge requests hidden.

Top module: `irq_pin_service`

## Requirements
- R1: A line event with level 0 clears that pin's request bit. A level pin whose request is withdrawn before its turn is not delivered.
- R2: An edge pin asserted while its request bit is clear sets the bit and is offered for delivery in the cycle after the event. Issuing it sets the pin's delivered bit.
- R3: An edge pin asserted while its request bit is already set is coalesced: nothing is delivered and its delivered bit is cleared.
- R4: A pin is never delivered while its mask bit is 1, or while it is level-triggered (trigger bit 1) with its remote-acknowledge flag set. Such a pending service is dropped.
- R5: A level delivery with the accept input high sets the pin's remote-acknowledge flag. A delivery that is not accepted leaves the flag clear.
- R6: An end-of-interrupt clears the remote-acknowledge flag of every level entry whose vector equals the broadcast vector. If the pin is unmasked and still requesting, it is serviced again.
- R7: Each such re-service increments a per-pin count. When the count would reach STORM_LIMIT it returns to zero and no immediate delivery happens. Exactly DEFER_CYCLES cycles after that end-of-interrupt, a sweep services every level pin that is requesting with its flag clear.
- R8: A matching end-of-interrupt on a level pin that is masked or not requesting resets that pin's count to zero.
- R9: An entry-rewrite pulse on a level pin with its request set starts a service attempt. On an edge pin it clears the remote-acknowledge flag.
- R10: At most one delivery is offered per cycle, always the lowest-numbered eligible pin.
- R11: The snapshot output equals the request register with the delivered bits cleared. It is all zero after reset.
- R12: A delivery carries the granted pin number and that entry's vector, destination and trigger bit. Valid is low when nothing is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineValid | input | 1 | Line event strobe |
| linePin | input | PIN_W | Pin number of the line event |
| lineLevel | input | 1 | New line level (1 asserted) |
| entMask | input | NUM_PINS | Per-pin mask bit, 1 = masked |
| entLevelTrig | input | NUM_PINS | Per-pin trigger mode, 1 = level, 0 = edge |
| entVector | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits i*VEC_W |
| entDest | input | NUM_PINS*DEST_W | Per-pin destination, pin i at bits i*DEST_W |
| entWrite | input | 1 | Entry-rewrite pulse |
| entWritePin | input | PIN_W | Pin whose entry was rewritten |
| eoiValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiVector | input | VEC_W | Vector carried by the broadcast |
| dlvValid | output | 1 | Delivery offered this cycle |
| dlvPin | output | PIN_W | Pin being delivered |
| dlvVector | output | VEC_W | Vector of the delivery |
| dlvDest | output | DEST_W | Destination of the delivery |
| dlvLevelTrig | output | 1 | Trigger mode of the delivery |
| dlvAccept | input | 1 | Delivery accepted (same cycle as dlvValid) |
| irrReport | output | NUM_PINS | Request register with delivered edge bits hidden |

## Verification
A line event, an entry rewrite or an end-of-interrupt sampled at one clock edge shows up as a delivery right after that edge. The accept input is taken at the next edge, together with the grant it answers. The deferred sweep of R7 appears exactly DEFER_CYCLES edges after the end-of-interrupt that hit the limit. The bench drives at the falling edge and samples there, so each result is read exactly one rising edge after its cause. A cycle-level reference model in the bench steps on the same edges and checks every offered delivery and the snapshot each cycle. Directed sequences count cycles explicitly around coalescing, storm deferral and priority.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;

  localparam int PIN_IDX_W = 8;

  typedef struct packed {
    logic                 issue;
    logic                 sweep;
    logic [PIN_IDX_W-1:0] grantIdx;
  } svc_strobe_t;

endpackage

// File: rtl/irq_svc_ctrl.sv
module irq_svc_ctrl
  import irq_svc_pkg::*;
#(
  parameter int NUM_PINS     = 24,
  parameter int DEFER_CYCLES = 1250000,
  localparam int TMR_W       = $clog2(DEFER_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] elig,
  input  logic                stormHit,
  output svc_strobe_t         st
);

  logic             busyQ;
  logic [TMR_W-1:0] tmrQ;
  logic             sweepNow;
  int               pick;

  // lowest eligible pin wins
  always_comb begin
    pick = 0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (elig[i]) pick = i;
    end
  end

  assign sweepNow = busyQ && (tmrQ == TMR_W'(DEFER_CYCLES - 1));

  always_comb begin
    st.issue    = |elig;
    st.sweep    = sweepNow;
    st.grantIdx = st.issue ? PIN_IDX_W'(pick) : '0;
  end

  // deferral timer: armed by a storm hit, fires one sweep
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      tmrQ  <= '0;
    end else begin
      if (sweepNow) busyQ <= stormHit;
      else          busyQ <= busyQ | stormHit;
      if (!busyQ || sweepNow) tmrQ <= '0;
      else                    tmrQ <= tmrQ + TMR_W'(1);
    end
  end

  logic [NUM_PINS-1:0] belowGrant;
  assign belowGrant = (NUM_PINS'(1) << st.grantIdx) - NUM_PINS'(1);

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    st.issue |-> elig[st.grantIdx]); // R10
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    st.issue |-> ((elig & belowGrant) == '0)); // R10
  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (tmrQ < TMR_W'(DEFER_CYCLES))); // R7

endmodule

// File: rtl/irq_svc_datapath.sv
module irq_svc_datapath
  import irq_svc_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int VEC_W       = 8,
  parameter int STORM_LIMIT = 10000,
  localparam int PIN_W      = $clog2(NUM_PINS),
  localparam int CNT_W      = $clog2(STORM_LIMIT + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lineValid,
  input  logic [PIN_W-1:0]          linePin,
  input  logic                      lineLevel,
  input  logic [NUM_PINS-1:0]       entMask,
  input  logic [NUM_PINS-1:0]       entLevelTrig,
  input  logic [NUM_PINS*VEC_W-1:0] entVector,
  input  logic                      entWrite,
  input  logic [PIN_W-1:0]          entWritePin,
  input  logic                      eoiValid,
  input  logic [VEC_W-1:0]          eoiVector,
  input  logic                      dlvAccept,
  input  svc_strobe_t               st,
  output logic [NUM_PINS-1:0]       elig,
  output logic                      stormHit,
  output logic [NUM_PINS-1:0]       irrReport
);

  logic [NUM_PINS-1:0] irrQ, dlvdQ, rirrQ, pendQ;
  logic [NUM_PINS-1:0] irrN, dlvdN, rirrN, pendN;
  logic [CNT_W-1:0]    cntQ [NUM_PINS];
  logic [CNT_W-1:0]    cntN [NUM_PINS];
  logic [NUM_PINS-1:0] vecHit, hitVec;
  logic [NUM_PINS-1:0] grantOh, lineOh, wrOh;

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PINS; gp++) begin : g_vec
      assign vecHit[gp] = eoiValid && (entVector[gp*VEC_W +: VEC_W] == eoiVector);
    end
  endgenerate

  assign elig = pendQ & ~entMask & (~entLevelTrig | (irrQ & ~rirrQ));

  always_comb begin
    grantOh = '0;
    lineOh  = '0;
    wrOh    = '0;
    if (st.issue) grantOh[st.grantIdx[PIN_W-1:0]] = 1'b1;
    if (lineValid) lineOh[linePin] = 1'b1;
    if (entWrite)  wrOh[entWritePin] = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      irrN[i]   = irrQ[i];
      dlvdN[i]  = dlvdQ[i];
      rirrN[i]  = rirrQ[i];
      pendN[i]  = pendQ[i] & elig[i] & ~grantOh[i];
      cntN[i]   = cntQ[i];
      hitVec[i] = 1'b0;
      // issue effects
      if (grantOh[i]) begin
        if (!entLevelTrig[i])  dlvdN[i] = 1'b1;
        else if (dlvAccept)    rirrN[i] = 1'b1;
      end
      // line event
      if (lineOh[i]) begin
        if (!lineLevel) begin
          irrN[i] = 1'b0;
        end else if (!entLevelTrig[i]) begin
          dlvdN[i] = 1'b0;
          if (!irrQ[i]) begin
            irrN[i]  = 1'b1;
            pendN[i] = 1'b1;
          end
        end else begin
          irrN[i]  = 1'b1;
          pendN[i] = 1'b1;
        end
      end
      // end-of-interrupt on level entries
      if (vecHit[i] && entLevelTrig[i]) begin
        rirrN[i] = 1'b0;
        if (!entMask[i] && irrN[i]) begin
          if (cntQ[i] + CNT_W'(1) == CNT_W'(STORM_LIMIT)) begin
            cntN[i]   = '0;
            hitVec[i] = 1'b1;
          end else begin
            cntN[i]  = cntQ[i] + CNT_W'(1);
            pendN[i] = 1'b1;
          end
        end else begin
          cntN[i] = '0;
        end
      end
      // entry rewrite
      if (wrOh[i]) begin
        if (!entLevelTrig[i]) rirrN[i] = 1'b0;
        else if (irrN[i])     pendN[i] = 1'b1;
      end
      // deferred sweep
      if (st.sweep && entLevelTrig[i] && irrN[i] && !rirrN[i]) pendN[i] = 1'b1;
    end
  end

  assign stormHit  = |hitVec;
  assign irrReport = irrQ & ~dlvdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrQ  <= '0;
      dlvdQ <= '0;
      rirrQ <= '0;
      pendQ <= '0;
      for (int i = 0; i < NUM_PINS; i++) cntQ[i] <= '0;
    end else begin
      irrQ  <= irrN;
      dlvdQ <= dlvdN;
      rirrQ <= rirrN;
      pendQ <= pendN;
      for (int i = 0; i < NUM_PINS; i++) cntQ[i] <= cntN[i];
    end
  end

  AST_DEASSERT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    lineValid && !lineLevel |=> !irrQ[$past(linePin)]); // R1
  AST_COALESCE_UNDELIVERED: assert property (@(posedge clk) disable iff (!rstN)
    lineValid && lineLevel && !entLevelTrig[linePin] && irrQ[linePin]
    |=> !dlvdQ[$past(linePin)]); // R3
  AST_ACCEPT_SETS_RIRR: assert property (@(posedge clk) disable iff (!rstN)
    st.issue && entLevelTrig[st.grantIdx[PIN_W-1:0]] && dlvAccept && !eoiValid && !entWrite
    |=> rirrQ[$past(st.grantIdx[PIN_W-1:0])]); // R5

  generate
    for (gp = 0; gp < NUM_PINS; gp++) begin : g_cnt_chk
      AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
        cntQ[gp] < CNT_W'(STORM_LIMIT)); // R7
    end
  endgenerate

endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
  import irq_svc_pkg::*;
#(
  parameter int NUM_PINS     = 24,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 1250000,
  localparam int PIN_W       = $clog2(NUM_PINS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lineValid,
  input  logic [PIN_W-1:0]           linePin,
  input  logic                       lineLevel,
  input  logic [NUM_PINS-1:0]        entMask,
  input  logic [NUM_PINS-1:0]        entLevelTrig,
  input  logic [NUM_PINS*VEC_W-1:0]  entVector,
  input  logic [NUM_PINS*DEST_W-1:0] entDest,
  input  logic                       entWrite,
  input  logic [PIN_W-1:0]           entWritePin,
  input  logic                       eoiValid,
  input  logic [VEC_W-1:0]           eoiVector,
  output logic                       dlvValid,
  output logic [PIN_W-1:0]           dlvPin,
  output logic [VEC_W-1:0]           dlvVector,
  output logic [DEST_W-1:0]          dlvDest,
  output logic                       dlvLevelTrig,
  input  logic                       dlvAccept,
  output logic [NUM_PINS-1:0]        irrReport
);

  svc_strobe_t         st;
  logic [NUM_PINS-1:0] elig;
  logic                stormHit;
  logic [PIN_W-1:0]    gIdx;

  irq_svc_datapath #(
    .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .STORM_LIMIT(STORM_LIMIT)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .lineValid(lineValid), .linePin(linePin), .lineLevel(lineLevel),
    .entMask(entMask), .entLevelTrig(entLevelTrig), .entVector(entVector),
    .entWrite(entWrite), .entWritePin(entWritePin),
    .eoiValid(eoiValid), .eoiVector(eoiVector),
    .dlvAccept(dlvAccept), .st(st),
    .elig(elig), .stormHit(stormHit), .irrReport(irrReport)
  );

  irq_svc_ctrl #(
    .NUM_PINS(NUM_PINS), .DEFER_CYCLES(DEFER_CYCLES)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .elig(elig), .stormHit(stormHit), .st(st)
  );

  assign gIdx         = st.grantIdx[PIN_W-1:0];
  assign dlvValid     = st.issue;
  assign dlvPin       = st.issue ? gIdx : '0;
  assign dlvVector    = st.issue ? entVector[gIdx*VEC_W +: VEC_W] : '0;
  assign dlvDest      = st.issue ? entDest[gIdx*DEST_W +: DEST_W] : '0;
  assign dlvLevelTrig = st.issue & entLevelTrig[gIdx];

  AST_MASKED_NEVER_SENT: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid |-> !entMask[dlvPin]); // R4

endmodule

// File: tb/irq_pin_service_tb.sv
module irq_pin_service_tb_top;

  localparam int NP  = 24;
  localparam int VW  = 8;
  localparam int DW  = 8;
  localparam int LIM = 4;
  localparam int DEF = 20;
  localparam int PW  = $clog2(NP);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic           lineValid = 0, lineLevel = 0, entWrite = 0, eoiValid = 0, dlvAccept = 0;
  logic [PW-1:0]  linePin = 0, entWritePin = 0;
  logic [VW-1:0]  eoiVector = 0;
  logic [NP-1:0]  entMask = '1, entLevelTrig = '0;
  logic [NP*VW-1:0] entVector = '0;
  logic [NP*DW-1:0] entDest = '0;
  logic           dlvValid, dlvLevelTrig;
  logic [PW-1:0]  dlvPin;
  logic [VW-1:0]  dlvVector;
  logic [DW-1:0]  dlvDest;
  logic [NP-1:0]  irrReport;

  irq_pin_service #(.NUM_PINS(NP), .VEC_W(VW), .DEST_W(DW),
                    .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)) dut_i (
    .clk(clk), .rstN(rstN), .lineValid(lineValid), .linePin(linePin), .lineLevel(lineLevel),
    .entMask(entMask), .entLevelTrig(entLevelTrig), .entVector(entVector), .entDest(entDest),
    .entWrite(entWrite), .entWritePin(entWritePin), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .dlvValid(dlvValid), .dlvPin(dlvPin), .dlvVector(dlvVector), .dlvDest(dlvDest),
    .dlvLevelTrig(dlvLevelTrig), .dlvAccept(dlvAccept), .irrReport(irrReport));

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  bit [NP-1:0] mIrr, mDlvd, mRirr, mPend;
  int mCnt [NP];
  bit mBusy;
  int mTcnt;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [NP-1:0] modelElig();
    return mPend & ~entMask & (~entLevelTrig | (mIrr & ~mRirr));
  endfunction

  function automatic int lowest(input bit [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic modelCompare();
    int g;
    g = lowest(modelElig());
    chk(dlvValid == (g >= 0), "R10 valid", dlvValid, g >= 0);
    if (g >= 0 && dlvValid) begin
      chk(dlvPin == PW'(g), "R10 pin", dlvPin, g);
      chk(dlvVector == entVector[g*VW +: VW], "R12 vector", dlvVector, entVector[g*VW +: VW]);
      chk(dlvDest == entDest[g*DW +: DW], "R12 dest", dlvDest, entDest[g*DW +: DW]);
      chk(dlvLevelTrig == entLevelTrig[g], "R12 trig", dlvLevelTrig, entLevelTrig[g]);
    end
    chk(irrReport == (mIrr & ~mDlvd), "R11 report", irrReport, mIrr & ~mDlvd);
  endtask

  task automatic modelAdvance();
    bit [NP-1:0] el, gOh, irrN, dlvN, rirrN, pendN;
    int cntN [NP];
    bit hit, sweep;
    int g;
    el = modelElig();
    g = lowest(el);
    gOh = '0;
    if (g >= 0) gOh[g] = 1'b1;
    sweep = mBusy && (mTcnt == DEF - 1);
    hit = 0;
    for (int i = 0; i < NP; i++) begin
      irrN[i] = mIrr[i]; dlvN[i] = mDlvd[i]; rirrN[i] = mRirr[i];
      pendN[i] = mPend[i] & el[i] & ~gOh[i]; cntN[i] = mCnt[i];
      if (gOh[i]) begin
        if (!entLevelTrig[i]) dlvN[i] = 1;
        else if (dlvAccept) rirrN[i] = 1;
      end
      if (lineValid && int'(linePin) == i) begin
        if (!lineLevel) irrN[i] = 0;
        else if (!entLevelTrig[i]) begin
          dlvN[i] = 0;
          if (!mIrr[i]) begin irrN[i] = 1; pendN[i] = 1; end
        end else begin irrN[i] = 1; pendN[i] = 1; end
      end
      if (eoiValid && entLevelTrig[i] && entVector[i*VW +: VW] == eoiVector) begin
        rirrN[i] = 0;
        if (!entMask[i] && irrN[i]) begin
          if (mCnt[i] + 1 == LIM) begin cntN[i] = 0; hit = 1; end
          else begin cntN[i] = mCnt[i] + 1; pendN[i] = 1; end
        end else cntN[i] = 0;
      end
      if (entWrite && int'(entWritePin) == i) begin
        if (!entLevelTrig[i]) rirrN[i] = 0;
        else if (irrN[i]) pendN[i] = 1;
      end
      if (sweep && entLevelTrig[i] && irrN[i] && !rirrN[i]) pendN[i] = 1;
    end
    mIrr = irrN; mDlvd = dlvN; mRirr = rirrN; mPend = pendN;
    for (int i = 0; i < NP; i++) mCnt[i] = cntN[i];
    mTcnt = (!mBusy || sweep) ? 0 : mTcnt + 1;
    mBusy = sweep ? hit : (mBusy | hit);
  endtask

  // one cycle: inputs already driven at the falling edge
  task automatic step();
    #1;
    modelCompare();
    modelAdvance();
    @(posedge clk);
    @(negedge clk);
    lineValid = 0; entWrite = 0; eoiValid = 0; dlvAccept = 0;
  endtask

  task automatic line(input int p, input bit lvl);
    lineValid = 1; linePin = PW'(p); lineLevel = lvl;
  endtask

  task automatic eoi(input int v);
    eoiValid = 1; eoiVector = VW'(v);
  endtask

  task automatic setEnt(input int p, input bit msk, input bit lvl, input int v, input int d);
    entMask[p] = msk; entLevelTrig[p] = lvl;
    entVector[p*VW +: VW] = VW'(v); entDest[p*DW +: DW] = DW'(d);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    summary();
  end

  initial begin
    int seed = 32'h5eed1234;
    void'($urandom(seed));
    mIrr = 0; mDlvd = 0; mRirr = 0; mPend = 0; mBusy = 0; mTcnt = 0;
    for (int i = 0; i < NP; i++) begin
      mCnt[i] = 0;
      setEnt(i, 0, 0, 8'h20 + i, i);
    end
    setEnt(3, 0, 0, 8'h33, 8'h81);
    setEnt(2, 0, 1, 8'h50, 8'h02);
    setEnt(9, 0, 1, 8'h50, 8'h09);
    setEnt(7, 0, 1, 8'h70, 8'h77);
    setEnt(12, 1, 0, 8'h3c, 8'h0c);
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk(dlvValid == 0, "R11 reset valid", dlvValid, 0);
    chk(irrReport == 0, "R11 reset report", irrReport, 0);

    // R2: fresh edge request
    line(3, 1); step();
    chk(dlvValid && dlvPin == 3, "R2 edge delivered", dlvPin, 3);
    chk(dlvVector == 8'h33 && dlvDest == 8'h81 && !dlvLevelTrig, "R12 fields", dlvVector, 8'h33);
    step();
    chk(irrReport[3] == 0, "R11 delivered hidden", irrReport[3], 0);
    // R3: coalesced assertion
    line(3, 1); step();
    chk(dlvValid == 0, "R3 no delivery", dlvValid, 0);
    chk(irrReport[3] == 1, "R3 delivered cleared", irrReport[3], 1);
    // R1: deassert
    line(3, 0); step();
    chk(irrReport[3] == 0, "R1 request cleared", irrReport[3], 0);
    // R4: masked pin
    line(12, 1); step();
    chk(dlvValid == 0, "R4 masked", dlvValid, 0);
    chk(irrReport[12] == 1, "R4 masked request held", irrReport[12], 1);
    // R5: level accept sets remote flag
    line(7, 1); step();
    chk(dlvValid && dlvPin == 7 && dlvLevelTrig, "R12 level delivery", dlvPin, 7);
    dlvAccept = 1; step();
    line(7, 1); step();
    chk(dlvValid == 0, "R5 remote flag blocks", dlvValid, 0);
    // R6 + R7 storm
    eoi(8'h70); step();
    chk(dlvValid && dlvPin == 7, "R6 re-service", dlvPin, 7);
    for (int k = 0; k < LIM - 2; k++) begin
      dlvAccept = 1; step();
      eoi(8'h70); step();
      chk(dlvValid && dlvPin == 7, "R6 re-service repeat", dlvValid, 1);
    end
    dlvAccept = 1; step();
    eoi(8'h70); step();
    chk(dlvValid == 0, "R7 storm deferred", dlvValid, 1'b0);
    for (int k = 0; k < DEF - 1; k++) begin
      step();
      chk(dlvValid == 0, "R7 hold during delay", dlvValid, 0);
    end
    step();
    chk(dlvValid && dlvPin == 7, "R7 sweep delivery", dlvPin, 7);
    // R8: count reset
    for (int k = 0; k < LIM - 1; k++) begin
      dlvAccept = 1; step();
      eoi(8'h70); step();
    end
    dlvAccept = 1; step();
    line(7, 0); step();
    eoi(8'h70); step();
    line(7, 1); step();
    chk(dlvValid && dlvPin == 7, "R1 level re-request", dlvPin, 7);
    dlvAccept = 1; step();
    eoi(8'h70); step();
    chk(dlvValid && dlvPin == 7, "R8 count was reset", dlvValid, 1);
    dlvAccept = 1; step();
    // R10: two pins released by one broadcast
    line(9, 1); step(); dlvAccept = 1; step();
    line(2, 1); step(); dlvAccept = 1; step();
    eoi(8'h50); step();
    chk(dlvValid && dlvPin == 2, "R10 lowest first", dlvPin, 2);
    step();
    chk(dlvValid && dlvPin == 9, "R10 next pin", dlvPin, 9);
    step();
    // R9: rewrite a requesting level entry (not accepted above, flag clear)
    chk(dlvValid == 0, "R5 unaccepted idle", dlvValid, 0);
    entWrite = 1; entWritePin = 9; step();
    chk(dlvValid && dlvPin == 9, "R9 rewrite service", dlvPin, 9);
    dlvAccept = 1; step();
    entLevelTrig[9] = 0; entWrite = 1; entWritePin = 9; step();
    entLevelTrig[9] = 1; entWrite = 1; entWritePin = 9; step();
    chk(dlvValid && dlvPin == 9, "R9 edge rewrite cleared flag", dlvPin, 9);
    step();

    // random phase against the model
    for (int i = 0; i < NP; i++)
      setEnt(i, ($urandom % 4) == 0, $urandom % 2, 8'h40 + ($urandom % 4), $urandom % 256);
    for (int c = 0; c < 3000; c++) begin
      if ($urandom % 2 == 0) line($urandom % NP, $urandom % 2);
      if ($urandom % 5 == 0) eoi(8'h40 + ($urandom % 4));
      if ($urandom % 20 == 0) begin entWrite = 1; entWritePin = PW'($urandom % NP); end
      if ($urandom % 50 == 0) entMask[$urandom % NP] ^= 1'b1;
      dlvAccept = ($urandom % 10) < 7;
      step();
    end
    summary();
  end

endmodule